// File: doc/BRIEF.md
# Reciprocal frequency counter core

This block measures an unknown sample clock against a fast reference clock by the equal-precision method. A host loads a gate limit, expressed in reference cycles, through a one-cycle write strobe in the reference domain. It then raises a count-enable level. The block opens a counting window on a sample-clock rising edge. The window stays open until the reference count has reached the limit, and it closes on a later sample-clock rising edge.

Over that window one counter counts reference cycles and the other counts sample cycles. Both windows begin and end on sample edges, so the sample count is exact. The reference count is off by at most one tick. When the window has closed, both counts are copied into holding registers and a done flag rises. The host reads the two counts at leisure and computes the sample frequency as f_ref times the sample count divided by the reference count. The run/stop control lives in the sample domain. The limit compare and the result registers live in the reference domain, and two-flop synchronisers carry the run level and the limit-reached level between the domains.

Top module: `recip_counter`

## Requirements
- R1: After reset, `done` is 1 and both `ref_count` and `smp_count` are 0.
- R2: A cycle with `lim_wr` high on `clk_ref` loads `lim_data` as the gate limit. The limit keeps its value across any number of measurements until it is written again or reset.
- R3: Only a 0-to-1 transition of `count_en` starts a measurement. Holding `count_en` high after a measurement starts nothing. Edges that arrive while a window is open or still closing are ignored.
- R4: `done` falls once counting has begun and stays low for the whole window. It rises only after both final counts are on the outputs.
- R5: The final reference count is at least the gate limit and at most limit + 6 + floor(3·Ts/Tr), where Ts and Tr are the sample and reference periods.
- R6: Both windows are bounded by sample-clock edges, so |ref_count·Tr − smp_count·Ts| < Tr.
- R7: While `done` is high, both outputs hold their values. Every new measurement starts both counters from zero, so the counts from earlier runs never add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; host writes and result registers use it |
| clk_smp | input | 1 | Sample clock being measured |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| lim_wr | input | 1 | Gate limit write strobe (clk_ref domain) |
| lim_data | input | 31 | Gate limit in reference cycles |
| count_en | input | 1 | Asynchronous enable level; its rising edge arms a measurement |
| done | output | 1 | High when idle with valid results; low during a measurement |
| ref_count | output | 31 | Held reference-cycle count of the last window |
| smp_count | output | 31 | Held sample-cycle count of the last window |

## Verification
A new enable edge and the closing of the window can fall in the same sample cycle. In that cycle the control logic must close the window without re-arming it. The bench provokes this by toggling `count_en` over and over during a run, so that edges land throughout the window and near its limit-driven close. The result is judged by a single rise of `done`, counts that meet the limit and precision bounds, and no further measurement starting after the run while the enable stays high.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_DRAIN = 2'd2
  } phase_t;
endpackage

// File: rtl/rfc_sync.sv
module rfc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rfc_smp_ctrl.sv
module rfc_smp_ctrl
  import rfc_pkg::*;
#(
  parameter int CNT_W       = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_smp,
  input  logic             rst,
  input  logic             count_en,
  input  logic             reach_async,
  output logic             run_o,
  output logic [CNT_W-1:0] smp_cnt_o
);
  phase_t           phase;
  logic             en_s, en_prev, reach_s, arm, run_q;
  logic [CNT_W-1:0] smp_cnt;

  rfc_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk(clk_smp), .rst(rst), .d(count_en), .q(en_s));
  rfc_sync #(.STAGES(SYNC_STAGES)) u_reach_sync (
    .clk(clk_smp), .rst(rst), .d(reach_async), .q(reach_s));

  assign arm = en_s & ~en_prev;

  always_ff @(posedge clk_smp) begin
    if (rst) begin
      phase   <= PH_IDLE;
      en_prev <= 1'b0;
      run_q   <= 1'b0;
      smp_cnt <= '0;
    end else begin
      en_prev <= en_s;
      case (phase)
        PH_IDLE: if (arm) begin
          phase   <= PH_RUN;
          run_q   <= 1'b1;
          smp_cnt <= '0;
        end
        PH_RUN: begin
          smp_cnt <= smp_cnt + 1'b1;
          if (reach_s) begin
            phase <= PH_DRAIN;
            run_q <= 1'b0;
          end
        end
        PH_DRAIN: if (!reach_s) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign run_o     = run_q;
  assign smp_cnt_o = smp_cnt;

  // R3: a window only opens on an enable edge seen in the previous cycle
  assert_start_needs_edge_R3: assert property (@(posedge clk_smp) disable iff (rst)
    $rose(run_q) |-> $past(arm));

  // R7: the sample count is frozen outside the window
  assert_smp_frozen_R7: assert property (@(posedge clk_smp) disable iff (rst)
    (!run_q && !$past(run_q)) |-> $stable(smp_cnt));
endmodule

// File: rtl/rfc_ref_ctrl.sv
module rfc_ref_ctrl #(
  parameter int CNT_W       = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             rst,
  input  logic             lim_wr,
  input  logic [CNT_W-1:0] lim_data,
  input  logic             run_async,
  input  logic [CNT_W-1:0] smp_cnt_in,
  output logic             reach_o,
  output logic             done_o,
  output logic [CNT_W-1:0] ref_count_o,
  output logic [CNT_W-1:0] smp_count_o
);
  logic             run_r, run_prev, cap, cap_d, reach_q, done_q;
  logic [CNT_W-1:0] limit_q, ref_cnt, hold_ref, hold_smp;

  rfc_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk(clk_ref), .rst(rst), .d(run_async), .q(run_r));

  // falling edge of the synchronised window marks the end of counting
  assign cap = run_prev & ~run_r;

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      limit_q  <= '0;
      run_prev <= 1'b0;
      ref_cnt  <= '0;
      reach_q  <= 1'b0;
      cap_d    <= 1'b0;
      done_q   <= 1'b1;
      hold_ref <= '0;
      hold_smp <= '0;
    end else begin
      run_prev <= run_r;
      cap_d    <= cap;
      if (lim_wr) limit_q <= lim_data;
      if (run_r) ref_cnt <= ref_cnt + 1'b1;
      else       ref_cnt <= '0;
      reach_q <= run_r && (ref_cnt >= limit_q);
      if (cap) begin
        hold_ref <= ref_cnt;
        hold_smp <= smp_cnt_in;
      end
      if (run_r)      done_q <= 1'b0;
      else if (cap_d) done_q <= 1'b1;
    end
  end

  assign reach_o     = reach_q;
  assign done_o      = done_q;
  assign ref_count_o = hold_ref;
  assign smp_count_o = hold_smp;

  // R4: done stays low while the synchronised window is open
  assert_done_low_in_window_R4: assert property (@(posedge clk_ref) disable iff (rst)
    run_prev |-> !done_q);

  // R7: results do not move while done is high
  assert_hold_stable_R7: assert property (@(posedge clk_ref) disable iff (rst)
    done_q |=> ($stable(hold_ref) && $stable(hold_smp)));
endmodule

// File: rtl/recip_counter.sv
module recip_counter #(
  parameter int CNT_W       = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             clk_smp,
  input  logic             rst,
  input  logic             lim_wr,
  input  logic [CNT_W-1:0] lim_data,
  input  logic             count_en,
  output logic             done,
  output logic [CNT_W-1:0] ref_count,
  output logic [CNT_W-1:0] smp_count
);
  logic             run_smp, reach_ref;
  logic [CNT_W-1:0] smp_cnt;

  rfc_smp_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk_smp    (clk_smp),
    .rst        (rst),
    .count_en   (count_en),
    .reach_async(reach_ref),
    .run_o      (run_smp),
    .smp_cnt_o  (smp_cnt)
  );

  rfc_ref_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ref (
    .clk_ref    (clk_ref),
    .rst        (rst),
    .lim_wr     (lim_wr),
    .lim_data   (lim_data),
    .run_async  (run_smp),
    .smp_cnt_in (smp_cnt),
    .reach_o    (reach_ref),
    .done_o     (done),
    .ref_count_o(ref_count),
    .smp_count_o(smp_count)
  );
endmodule

// File: tb/recip_counter_bench.sv
`timescale 1ns/1ps
module recip_counter_bench;
  localparam int W  = 31;
  localparam int TR = 10;

  logic clk_ref = 1'b0, clk_smp = 1'b0, rst = 1'b1;
  logic lim_wr = 1'b0, count_en = 1'b0;
  logic [W-1:0] lim_data = '0;
  logic done;
  logic [W-1:0] ref_count, smp_count;

  int n_checks = 0, n_err = 0;
  real smp_half = 18.5;
  logic prev_done = 1'b1;
  logic [W-1:0] prev_ref = '0, prev_smp = '0;

  recip_counter u_recip_counter (
    .clk_ref(clk_ref), .clk_smp(clk_smp), .rst(rst),
    .lim_wr(lim_wr), .lim_data(lim_data), .count_en(count_en),
    .done(done), .ref_count(ref_count), .smp_count(smp_count));

  always #5 clk_ref = ~clk_ref;
  initial begin
    #0.3;
    forever #(smp_half) clk_smp = ~clk_smp;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R7 per-cycle model: results must not move while done stays high
  always @(negedge clk_ref) begin
    if (!rst && done && prev_done) begin
      check(ref_count == prev_ref, "R7 ref hold", longint'(ref_count), longint'(prev_ref));
      check(smp_count == prev_smp, "R7 smp hold", longint'(smp_count), longint'(prev_smp));
    end
    prev_done = done;
    prev_ref  = ref_count;
    prev_smp  = smp_count;
  end

  task automatic write_limit(input int lim);
    @(negedge clk_ref);
    lim_wr = 1'b1; lim_data = W'(lim);
    @(negedge clk_ref);
    lim_wr = 1'b0;
  endtask

  task automatic measure(input int lim, input int ts, input bit toggle);
    longint nr, ns, diff;
    smp_half = ts / 2.0;
    repeat (8) @(negedge clk_smp);
    @(negedge clk_ref);
    count_en = 1'b1;
    while (done) @(negedge clk_ref);
    check(done == 1'b0, "R4 done low in window", longint'(done), 0);
    if (toggle) begin
      for (int k = 0; k < 40 && !done; k++) begin
        repeat (3) @(negedge clk_smp);
        count_en = ~count_en;
      end
      count_en = 1'b1;
    end
    while (!done) @(negedge clk_ref);
    nr = longint'(ref_count);
    ns = longint'(smp_count);
    check(nr >= lim, "R5 ref count reaches limit", nr, lim);
    check(nr <= lim + 6 + (3 * ts) / TR, "R5 ref overrun bound", nr, lim + 6 + (3 * ts) / TR);
    diff = nr * TR - ns * ts;
    if (diff < 0) diff = -diff;
    check(diff < TR, "R6 windows agree within one ref tick", diff, TR - 1);
    // enable left high: nothing new may start
    repeat (25) @(negedge clk_smp);
    @(negedge clk_ref);
    check(done == 1'b1, "R3 level high starts nothing", longint'(done), 1);
    check(longint'(ref_count) == nr, "R3 counts unchanged while idle", longint'(ref_count), nr);
    count_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL R4 watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (20) @(negedge clk_ref);
    rst = 1'b0;
    @(negedge clk_ref);
    check(done == 1'b1, "R1 done after reset", longint'(done), 1);
    check(ref_count == '0, "R1 ref_count after reset", longint'(ref_count), 0);
    check(smp_count == '0, "R1 smp_count after reset", longint'(smp_count), 0);

    write_limit(1000);
    measure(1000, 37, 1'b0);
    write_limit(2500);
    measure(2500, 23, 1'b0);
    // R2: no rewrite, limit 2500 must still apply; R7: fresh start from zero
    measure(2500, 71, 1'b0);
    // R3: enable toggled through the window and near its close
    write_limit(1200);
    measure(1200, 29, 1'b1);
    // R5 corner: zero limit
    write_limit(0);
    measure(0, 41, 1'b0);
    write_limit(1);
    measure(1, 13, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule